// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical address for a real-mode style memory bus. It holds four segment registers: extra, code, stack and data. Each request names the kind of access and the register that supplied the offset. From these two fields the block picks the default segment and shifts that segment left by four bit positions. It then adds the zero-extended offset, keeps only the low 20 bits, and presents the result on a registered output with a one-cycle valid strobe.

Software or a sequencer loads the segment registers through a single write port. A request in the same cycle as a write sees the value from before the write. The address space is exactly 1 MB, from 00000h to FFFFFh. Any sum above that wraps around to the bottom of the space.

Top module: `seg_addr_gen`

## Requirements
- R1: After synchronous reset, `addr_valid` is 0 and `phys_addr` is 00000h. The code segment holds FFFFh and the other three segments hold 0000h.
- R2: A request sampled with `req_valid`=1 on a rising edge produces `addr_valid`=1 for exactly one cycle, starting at that edge. A cycle without a request gives `addr_valid`=0.
- R3: `phys_addr` = (segment × 16 + offset) mod 2^20. No carry beyond bit 19 is kept. Example: segment FFFFh with offset FFFFh gives 0FFEFh.
- R4: `req_kind`=0 (instruction fetch) uses the code segment, whatever the value of `req_base`.
- R5: `req_kind`=1 (stack access) uses the stack segment.
- R6: `req_kind`=2 (data access) uses the data segment. The exception is `req_base`=4 (base pointer) or 5 (stack pointer), which selects the stack segment. The other base codes are 0 displacement, 1 BX, 2 SI, 3 DI, 6 IP and 7 spare.
- R7: `req_kind`=3 (string destination) uses the extra segment.
- R8: A write with `seg_wr_en`=1 loads `seg_wr_data` into the segment chosen by `seg_wr_sel`: 0 extra, 1 code, 2 stack, 3 data. The new value applies to requests from the next cycle on. A request in the same cycle uses the old value.
- R9: While no request arrives, `phys_addr` holds the last generated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_wr_en | input | 1 | Segment register write enable |
| seg_wr_sel | input | 2 | Segment to write: 0 extra, 1 code, 2 stack, 3 data |
| seg_wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | 0 fetch, 1 stack, 2 data, 3 string destination |
| req_base | input | 3 | Offset source register code |
| req_offset | input | 16 | Effective offset |
| addr_valid | output | 1 | Registered address strobe |
| phys_addr | output | 20 | Registered 20-bit physical address |

## Verification
The bench drives sums above FFFFFh. A design that kept a carry, or that added the offset before shifting the segment, would return an address that is not wrapped or is misaligned.

A data access with the base pointer as offset source must land in the stack segment. A design that chose the segment from the access kind alone would land in the data segment.

A write and a request in the same cycle must use the old segment value. A design that bypassed the write would show the new value one request early.

After reset, a fetch is checked for FFFF0h. This catches a code segment that clears to zero like the others.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W   = 16;
  localparam int NUM_SEG = 4;
  localparam int SEL_W   = $clog2(NUM_SEG);

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_STACK  = 2'd1,
    ACC_DATA   = 2'd2,
    ACC_STRDST = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    BASE_DISP = 3'd0,
    BASE_BX   = 3'd1,
    BASE_SI   = 3'd2,
    BASE_DI   = 3'd3,
    BASE_BP   = 3'd4,
    BASE_SP   = 3'd5,
    BASE_IP   = 3'd6,
    BASE_NONE = 3'd7
  } base_src_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W    = 16,
  parameter int NUM_SEG  = 4,
  parameter int CODE_IDX = 1,
  localparam int SEL_W   = $clog2(NUM_SEG)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [SEL_W-1:0]                  wr_sel,
  input  logic [SEG_W-1:0]                  wr_data,
  output logic [NUM_SEG-1:0][SEG_W-1:0]     seg_q
);
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL = (g == CODE_IDX) ? {SEG_W{1'b1}} : '0;
    always_ff @(posedge clk) begin
      if (rst) begin
        seg_q[g] <= RST_VAL;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        seg_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic [1:0]       kind,
  input  logic [2:0]       base,
  output logic [SEL_W-1:0] seg_idx
);
  always_comb begin
    unique case (acc_kind_e'(kind))
      ACC_FETCH:  seg_idx = SEG_CODE;
      ACC_STACK:  seg_idx = SEG_STACK;
      ACC_STRDST: seg_idx = SEG_EXTRA;
      default: begin
        if (base == BASE_BP || base == BASE_SP) seg_idx = SEG_STACK;
        else                                    seg_idx = SEG_DATA;
      end
    endcase
  end
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr
);
  logic [ADDR_W-1:0] base_shifted;
  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] sum;

  assign base_shifted = {seg, {SHIFT{1'b0}}};
  assign off_ext      = ADDR_W'(off);
  assign sum          = base_shifted + off_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= sum;
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seg_wr_en,
  input  logic [1:0]        seg_wr_sel,
  input  logic [15:0]       seg_wr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [2:0]        req_base,
  input  logic [OFF_W-1:0]  req_offset,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] phys_addr
);
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  logic [SEL_W-1:0]              seg_idx;

  seg_regfile #(
    .SEG_W   (SEG_W),
    .NUM_SEG (NUM_SEG),
    .CODE_IDX(int'(SEG_CODE))
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (seg_wr_en),
    .wr_sel (seg_wr_sel),
    .wr_data(seg_wr_data),
    .seg_q  (seg_q)
  );

  seg_select u_sel (
    .kind   (req_kind),
    .base   (req_base),
    .seg_idx(seg_idx)
  );

  addr_adder #(
    .SEG_W(SEG_W),
    .OFF_W(OFF_W),
    .SHIFT(SHIFT)
  ) u_add (
    .clk      (clk),
    .rst      (rst),
    .in_valid (req_valid),
    .seg      (seg_q[seg_idx]),
    .off      (req_offset),
    .out_valid(addr_valid),
    .out_addr (phys_addr)
  );
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        seg_wr_en,
  input logic [1:0]  seg_wr_sel,
  input logic [15:0] seg_wr_data,
  input logic        req_valid,
  input logic [1:0]  req_kind,
  input logic [2:0]  req_base,
  input logic [15:0] req_offset,
  input logic        addr_valid,
  input logic [19:0] phys_addr
);
  logic [15:0] shadow [4];
  logic [1:0]  pick;
  logic [19:0] exp_now;
  logic [19:0] exp_q;
  logic        was_rst;

  always_comb begin
    if (req_kind == 2'd0)      pick = 2'd1;
    else if (req_kind == 2'd1) pick = 2'd2;
    else if (req_kind == 2'd3) pick = 2'd0;
    else if (req_base == 3'd4 || req_base == 3'd5) pick = 2'd2;
    else pick = 2'd3;
  end

  assign exp_now = ({4'h0, shadow[pick]} << 4) + {4'h0, req_offset};

  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (rst) begin
      shadow[0] <= 16'h0000;
      shadow[1] <= 16'hFFFF;
      shadow[2] <= 16'h0000;
      shadow[3] <= 16'h0000;
      exp_q     <= '0;
    end else begin
      if (seg_wr_en) shadow[seg_wr_sel] <= seg_wr_data;
      if (req_valid) exp_q <= exp_now;
    end
  end

  always @(negedge clk) begin
    if (was_rst && !rst) begin
      AST_RESET_CLEAR: assert (!addr_valid && phys_addr == 20'h0); // R1
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !addr_valid); // R2
  AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> phys_addr == exp_q); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !was_rst) |=> $stable(phys_addr)); // R9
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .seg_wr_en  (seg_wr_en),
  .seg_wr_sel (seg_wr_sel),
  .seg_wr_data(seg_wr_data),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .req_base   (req_base),
  .req_offset (req_offset),
  .addr_valid (addr_valid),
  .phys_addr  (phys_addr)
);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [2:0]  req_base = '0;
  logic [15:0] req_offset = '0;
  logic        addr_valid;
  logic [19:0] phys_addr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst(rst),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .req_base(req_base),
    .req_offset(req_offset), .addr_valid(addr_valid), .phys_addr(phys_addr)
  );

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic wr_seg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
    @(negedge clk);
    seg_wr_en = 1'b0;
  endtask

  task automatic do_req(input string tag, input logic [1:0] kind, input logic [2:0] base,
                        input logic [15:0] off, input logic [19:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_base = base; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {19'h0, addr_valid}, 20'h1);
    check(tag, phys_addr, exp);
    @(negedge clk);
    check({tag, " one-cycle R2"}, {19'h0, addr_valid}, 20'h0);
  endtask

  task automatic t_reset;
    check("R1 valid after reset", {19'h0, addr_valid}, 20'h0);
    check("R1 addr after reset", phys_addr, 20'h0);
    do_req("R1 R4 code seg reset", 2'd0, 3'd6, 16'h0000, 20'hFFFF0);
    do_req("R1 data seg reset", 2'd2, 3'd1, 16'h1234, 20'h01234);
  endtask

  task automatic t_kinds;
    wr_seg(2'd0, 16'h4900);
    wr_seg(2'd1, 16'h2000);
    wr_seg(2'd2, 16'h3400);
    wr_seg(2'd3, 16'h1000);
    do_req("R4 fetch", 2'd0, 3'd2, 16'h3000, 20'h23000);
    do_req("R5 stack", 2'd1, 3'd5, 16'h0010, 20'h34010);
    do_req("R6 data BX", 2'd2, 3'd1, 16'h0005, 20'h10005);
    do_req("R6 data BP", 2'd2, 3'd4, 16'h0020, 20'h34020);
    do_req("R6 data SP", 2'd2, 3'd5, 16'h0002, 20'h34002);
    do_req("R6 data DI", 2'd2, 3'd3, 16'h0040, 20'h10040);
    do_req("R7 string dest", 2'd3, 3'd3, 16'h0100, 20'h49100);
  endtask

  task automatic t_wrap;
    wr_seg(2'd1, 16'hFFFF);
    do_req("R3 wrap", 2'd0, 3'd6, 16'hFFFF, 20'h0FFEF);
    wr_seg(2'd3, 16'h1234);
    do_req("R3 segment end", 2'd2, 3'd0, 16'hFFFF, 20'h2233F);
    do_req("R3 segment start", 2'd2, 3'd0, 16'h0000, 20'h12340);
  endtask

  task automatic t_same_cycle;
    wr_seg(2'd3, 16'h1000);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = 2'd3; seg_wr_data = 16'h5000;
    req_valid = 1'b1; req_kind = 2'd2; req_base = 3'd2; req_offset = 16'h0000;
    @(negedge clk);
    seg_wr_en = 1'b0; req_valid = 1'b0;
    check("R8 same-cycle old value", phys_addr, 20'h10000);
    do_req("R8 new value", 2'd2, 3'd2, 16'h0000, 20'h50000);
  endtask

  task automatic t_hold;
    logic [19:0] last;
    do_req("R9 setup", 2'd1, 3'd4, 16'h0ABC, 20'h34ABC);
    last = phys_addr;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 hold addr", phys_addr, last);
      check("R2 idle valid", {19'h0, addr_valid}, 20'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_kinds();
    t_wrap();
    t_same_cycle();
    t_hold();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule